// File: doc/BRIEF.md
# Shadowed Nonvolatile Register File Controller

This block is the storage backend that sits behind a two-wire serial slave. The serial front end hands it byte-wide reads and writes at an 8-bit register address, plus a strobe when the bus STOP condition is seen. The block holds three kinds of storage. The first is a 64-byte user area that is always nonvolatile. The second is a bank of eight configuration registers, each backed by a volatile copy and a nonvolatile copy. The third is six bytes of plain SRAM. It also assembles a read-only status byte from the levels of four general-purpose pins.

Writes to nonvolatile storage are staged and committed as a whole page when STOP arrives. A timed commit then runs, and `busy` is raised for its full duration so the front end can refuse its slave address while the commit is in progress. A configuration bit selects whether writes to the shadowed registers stay volatile or are also committed. On every reset the shadowed registers reload the last committed values. The nonvolatile array is a register model with a cycle-count write time. A separate clear input loads its factory image.

Top module: `nvrf_ctrl`

## Requirements
- R1: Addresses 40h–EFh are reserved: a read returns 00h and a write changes no readable state.
- R2: Addresses FAh–FFh are plain SRAM bytes. Each reads back the last value written and returns to 00h on reset. A write to them never starts a commit.
- R3: A write to a user byte (00h–3Fh) reaches nonvolatile storage only through a commit. Until the commit completes, a read returns the previously stored value. STOP raises `busy` from the next cycle for exactly COMMIT_CYCLES cycles. After that the new value reads back, and it is kept through a reset.
- R4: One commit rewrites one 8-byte user page, selected by address bits 5:3 of the first user write since the last commit. Bytes of that page that were not written keep their stored contents. Writes to any other user page before the commit are ignored.
- R5: With bit 0 of the config register (F9h) set to 1, a write to a shadowed register (F0h–F7h) takes effect at once but starts no commit at STOP. After a reset, the register shows its old committed value again.
- R6: With config bit 0 cleared (the reset value), a write to a shadowed register marks it for commit. STOP then commits all eight shadowed registers, and their values are kept through a reset.
- R7: While a commit is running, every write, to any address, is ignored.
- R8: A read of F8h returns the pin levels in bits 3:0 (pin i in bit i), with bits 7:4 reading 0.
- R9: `pullup_en[i]` is bit i of F0h. `pulldown_en[i]` is the inverse of bit 0 of register F4h+i. `delay_sel` is bits 1:0 of F1h. The factory values are F0h=00h, F1h=03h, F2h=F3h=00h and F4h–F7h=01h.
- R10: After reset is released, `busy` is high for one cycle while the shadowed registers reload from nonvolatile storage.
- R11: A STOP with no pending nonvolatile write leaves `busy` low.
- R12: Read data appears on `rdata` one cycle after `rd_en` and holds until the next read. F9h reads as 0000000b followed by the mode bit.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset of all volatile state (power-up) |
| nv_clear_n | input | 1 | Active-low load of the factory image into the nonvolatile model |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 8 | Register address |
| wdata | input | 8 | Write data |
| stop_i | input | 1 | One-cycle pulse on bus STOP |
| pin_lvl | input | 4 | Sampled levels of the four pins |
| rdata | output | 8 | Registered read data |
| busy | output | 1 | Commit or recall in progress; writes are refused |
| pullup_en | output | 4 | Per-pin pull-up enable |
| pulldown_en | output | 4 | Per-pin pull-down enable |
| delay_sel | output | 2 | Reset delay selection field |

## Verification
Read data is registered, so each expected byte is queued when `rd_en` is driven and compared at the falling edge after the rising edge that captured the read. Pin-control outputs follow a write in the next cycle and are sampled at the falling edge that follows. `busy` rises in the cycle after the STOP strobe is captured and is counted at each falling edge until it drops. The count must equal COMMIT_CYCLES for a commit and zero for a STOP with nothing pending. After a reset release, `busy` is sampled at two successive falling edges to confirm the one-cycle recall, and persistence is then checked by reading the reloaded values.

// File: rtl/nvrf_pkg.sv
package nvrf_pkg;

    localparam logic [7:0] SHD_BASE  = 8'hF0;
    localparam logic [7:0] STAT_ADDR = 8'hF8;
    localparam logic [7:0] CFG_ADDR  = 8'hF9;
    localparam logic [7:0] SRAM_BASE = 8'hFA;

    localparam int SHD_BYTES  = 8;
    localparam int SRAM_BYTES = 6;

    // factory image of the shadowed bank, byte k belongs to address F0h+k
    localparam logic [SHD_BYTES*8-1:0] SHD_FACTORY =
        {8'h01, 8'h01, 8'h01, 8'h01, 8'h00, 8'h00, 8'h03, 8'h00};

    typedef enum logic [2:0] {
        RGN_USER,
        RGN_RSVD,
        RGN_SHADOW,
        RGN_STATUS,
        RGN_CFG,
        RGN_SRAM
    } region_e;

endpackage

// File: rtl/nvrf_decode.sv
module nvrf_decode
    import nvrf_pkg::*;
#(
    parameter int USER_BYTES = 64
) (
    input  logic [7:0] addr,
    output region_e    rgn,
    output logic [2:0] idx
);

    always_comb begin
        idx = addr[2:0];
        if (int'(addr) < USER_BYTES) begin
            rgn = RGN_USER;
        end else if (addr < SHD_BASE) begin
            rgn = RGN_RSVD;
        end else if (addr < STAT_ADDR) begin
            rgn = RGN_SHADOW;
        end else if (addr == STAT_ADDR) begin
            rgn = RGN_STATUS;
        end else if (addr == CFG_ADDR) begin
            rgn = RGN_CFG;
        end else begin
            rgn = RGN_SRAM;
            idx = 3'(addr - SRAM_BASE);
        end
    end

endmodule

// File: rtl/nvrf_array.sv
module nvrf_array
    import nvrf_pkg::*;
#(
    parameter int USER_BYTES = 64,
    parameter int PAGE_BYTES = 8,
    localparam int PAGES = USER_BYTES / PAGE_BYTES,
    localparam int PG_W  = $clog2(PAGES),
    localparam int UA_W  = $clog2(USER_BYTES),
    localparam int PB8   = PAGE_BYTES * 8,
    localparam int SB8   = SHD_BYTES * 8
) (
    input  logic            clk,
    input  logic            clear_n,
    input  logic            page_we,
    input  logic [PG_W-1:0] page_sel,
    input  logic [PB8-1:0]  page_data,
    input  logic            shd_we,
    input  logic [SB8-1:0]  shd_data,
    input  logic [UA_W-1:0] rd_addr,
    output logic [7:0]      rd_byte,
    output logic [PB8-1:0]  page_image,
    output logic [SB8-1:0]  shd_image
);

    typedef struct packed {
        logic [USER_BYTES*8-1:0] user;
        logic [SB8-1:0]          shd;
    } arr_t;

    arr_t arr_d, arr_q;

    always_comb begin
        arr_d = arr_q;
        if (page_we) begin
            arr_d.user[int'(page_sel)*PB8 +: PB8] = page_data;
        end
        if (shd_we) begin
            arr_d.shd = shd_data;
        end
    end

    always_ff @(posedge clk or negedge clear_n) begin
        if (!clear_n) begin
            arr_q <= '{user: '0, shd: SHD_FACTORY};
        end else begin
            arr_q <= arr_d;
        end
    end

    assign rd_byte    = arr_q.user[int'(rd_addr)*8 +: 8];
    assign page_image = arr_q.user[int'(page_sel)*PB8 +: PB8];
    assign shd_image  = arr_q.shd;

    AST_NV_ONLY_ON_COMMIT: assert property (@(posedge clk) disable iff (!clear_n)
        (!page_we && !shd_we) |=> $stable(arr_q)); // R3

endmodule

// File: rtl/nvrf_commit.sv
module nvrf_commit #(
    parameter int COMMIT_CYCLES = 2_000_000,
    localparam int CW = $clog2(COMMIT_CYCLES + 1)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    output logic busy,
    output logic done
);

    typedef struct packed {
        logic          busy;
        logic [CW-1:0] cnt;
    } tmr_t;

    tmr_t tmr_d, tmr_q;

    always_comb begin
        tmr_d = tmr_q;
        if (!tmr_q.busy) begin
            if (start) begin
                tmr_d.busy = 1'b1;
                tmr_d.cnt  = CW'(COMMIT_CYCLES - 1);
            end
        end else if (tmr_q.cnt == '0) begin
            tmr_d.busy = 1'b0;
        end else begin
            tmr_d.cnt = tmr_q.cnt - 1'b1;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            tmr_q <= '0;
        end else begin
            tmr_q <= tmr_d;
        end
    end

    assign busy = tmr_q.busy;
    assign done = tmr_q.busy && (tmr_q.cnt == '0);

    AST_COMMIT_NEEDS_START: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(busy) |-> $past(start)); // R3
    AST_COMMIT_ENDS: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !busy); // R3

endmodule

// File: rtl/nvrf_ctrl.sv
module nvrf_ctrl
    import nvrf_pkg::*;
#(
    parameter int USER_BYTES    = 64,
    parameter int PAGE_BYTES    = 8,
    parameter int COMMIT_CYCLES = 2_000_000,
    parameter int PINS          = 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            nv_clear_n,
    input  logic            wr_en,
    input  logic            rd_en,
    input  logic [7:0]      addr,
    input  logic [7:0]      wdata,
    input  logic            stop_i,
    input  logic [PINS-1:0] pin_lvl,
    output logic [7:0]      rdata,
    output logic            busy,
    output logic [PINS-1:0] pullup_en,
    output logic [PINS-1:0] pulldown_en,
    output logic [1:0]      delay_sel
);

    localparam int PAGES = USER_BYTES / PAGE_BYTES;
    localparam int PG_W  = $clog2(PAGES);
    localparam int UA_W  = $clog2(USER_BYTES);
    localparam int OFS_W = $clog2(PAGE_BYTES);
    localparam int PB8   = PAGE_BYTES * 8;
    localparam int SB8   = SHD_BYTES * 8;
    localparam int CTL0  = 4;   // first pin-control byte inside the shadowed bank

    typedef struct packed {
        logic [SB8-1:0]          shd;
        logic [SRAM_BYTES*8-1:0] sram;
        logic                    vol;
        logic                    pend_u;
        logic [PG_W-1:0]         pg;
        logic [PB8-1:0]          pbuf;
        logic [PAGE_BYTES-1:0]   pmask;
        logic                    pend_s;
        logic                    recall;
        logic [7:0]              rdata;
    } st_t;

    st_t st_d, st_q;

    region_e         rgn;
    logic [2:0]      idx;
    logic [7:0]      nv_rd_byte;
    logic [PB8-1:0]  nv_page;
    logic [SB8-1:0]  nv_shd;
    logic [PB8-1:0]  merged;
    logic            cm_start, cm_busy, cm_done;
    logic            busy_all;
    logic [PG_W-1:0] wr_pg;
    logic [OFS_W-1:0] wr_ofs;

    nvrf_decode #(.USER_BYTES(USER_BYTES)) u_dec (
        .addr (addr),
        .rgn  (rgn),
        .idx  (idx)
    );

    nvrf_array #(.USER_BYTES(USER_BYTES), .PAGE_BYTES(PAGE_BYTES)) u_arr (
        .clk        (clk),
        .clear_n    (nv_clear_n),
        .page_we    (cm_done && st_q.pend_u),
        .page_sel   (st_q.pg),
        .page_data  (merged),
        .shd_we     (cm_done && st_q.pend_s),
        .shd_data   (st_q.shd),
        .rd_addr    (addr[UA_W-1:0]),
        .rd_byte    (nv_rd_byte),
        .page_image (nv_page),
        .shd_image  (nv_shd)
    );

    nvrf_commit #(.COMMIT_CYCLES(COMMIT_CYCLES)) u_cmt (
        .clk   (clk),
        .rst_n (rst_n),
        .start (cm_start),
        .busy  (cm_busy),
        .done  (cm_done)
    );

    assign busy_all = cm_busy || st_q.recall;
    assign wr_pg    = addr[UA_W-1:OFS_W];
    assign wr_ofs   = addr[OFS_W-1:0];

    // staged bytes over stored bytes for the page being committed
    always_comb begin
        for (int b = 0; b < PAGE_BYTES; b++) begin
            merged[b*8 +: 8] = st_q.pmask[b] ? st_q.pbuf[b*8 +: 8] : nv_page[b*8 +: 8];
        end
    end

    always_comb begin
        st_d     = st_q;
        cm_start = 1'b0;

        if (st_q.recall) begin
            st_d.shd    = nv_shd;
            st_d.recall = 1'b0;
        end

        if (wr_en && !busy_all) begin
            unique case (rgn)
                RGN_USER: begin
                    if (!st_q.pend_u || st_q.pg == wr_pg) begin
                        st_d.pend_u                        = 1'b1;
                        st_d.pg                            = wr_pg;
                        st_d.pbuf[int'(wr_ofs)*8 +: 8]     = wdata;
                        st_d.pmask[wr_ofs]                 = 1'b1;
                    end
                end
                RGN_SHADOW: begin
                    st_d.shd[int'(idx)*8 +: 8] = wdata;
                    if (!st_q.vol) begin
                        st_d.pend_s = 1'b1;
                    end
                end
                RGN_CFG:  st_d.vol = wdata[0];
                RGN_SRAM: st_d.sram[int'(idx)*8 +: 8] = wdata;
                default: ;
            endcase
        end

        if (rd_en) begin
            unique case (rgn)
                RGN_USER:   st_d.rdata = nv_rd_byte;
                RGN_SHADOW: st_d.rdata = st_q.shd[int'(idx)*8 +: 8];
                RGN_STATUS: st_d.rdata = 8'(pin_lvl);
                RGN_CFG:    st_d.rdata = {7'b0, st_q.vol};
                RGN_SRAM:   st_d.rdata = st_q.sram[int'(idx)*8 +: 8];
                default:    st_d.rdata = 8'h00;
            endcase
        end

        if (stop_i && !busy_all && (st_q.pend_u || st_q.pend_s)) begin
            cm_start = 1'b1;
        end

        if (cm_done) begin
            st_d.pend_u = 1'b0;
            st_d.pmask  = '0;
            st_d.pend_s = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q        <= '0;
            st_q.shd    <= SHD_FACTORY;
            st_q.recall <= 1'b1;
        end else begin
            st_q <= st_d;
        end
    end

    assign rdata     = st_q.rdata;
    assign busy      = busy_all;
    assign pullup_en = st_q.shd[PINS-1:0];
    assign delay_sel = st_q.shd[9:8];

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign pulldown_en[p] = ~st_q.shd[(CTL0 + p)*8];
    end

    AST_RSVD_READS_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rgn == RGN_RSVD) |=> (rdata == 8'h00)); // R1
    AST_STATUS_UPPER_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_en && rgn == RGN_STATUS) |=> ((rdata >> PINS) == 8'h00)); // R8
    AST_BUSY_BLOCKS_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && cm_busy) |=> ($stable(st_q.sram) && $stable(st_q.shd) && $stable(st_q.vol))); // R7
    AST_IDLE_STOP_NO_BUSY: assert property (@(posedge clk) disable iff (!rst_n)
        (stop_i && !busy_all && !st_q.pend_u && !st_q.pend_s) |=> !cm_busy); // R11
    AST_VOLATILE_NO_PEND: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !busy_all && rgn == RGN_SHADOW && st_q.vol && !st_q.pend_s) |=> !st_q.pend_s); // R5

endmodule

// File: tb/nvrf_ctrl_bench.sv
module nvrf_ctrl_bench;

    localparam int CC = 40;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       nv_clear_n = 1'b0;
    logic       wr_en = 1'b0;
    logic       rd_en = 1'b0;
    logic [7:0] addr = 8'h00;
    logic [7:0] wdata = 8'h00;
    logic       stop_i = 1'b0;
    logic [3:0] pin_lvl = 4'h0;
    logic [7:0] rdata;
    logic       busy;
    logic [3:0] pullup_en;
    logic [3:0] pulldown_en;
    logic [1:0] delay_sel;

    int checks = 0;
    int fails  = 0;

    typedef struct {
        logic [7:0] exp;
        string      req;
    } exp_t;
    exp_t sbq[$];
    logic mon_pend = 1'b0;

    always #5 clk = ~clk;

    nvrf_ctrl #(.COMMIT_CYCLES(CC)) u_nvrf_ctrl (
        .clk         (clk),
        .rst_n       (rst_n),
        .nv_clear_n  (nv_clear_n),
        .wr_en       (wr_en),
        .rd_en       (rd_en),
        .addr        (addr),
        .wdata       (wdata),
        .stop_i      (stop_i),
        .pin_lvl     (pin_lvl),
        .rdata       (rdata),
        .busy        (busy),
        .pullup_en   (pullup_en),
        .pulldown_en (pulldown_en),
        .delay_sel   (delay_sel)
    );

    task automatic check(input int got, input int exp, input string req);
        checks++;
        if (got != exp) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", req, got, exp);
        end
    endtask

    // monitor: a read captured at a rising edge is compared at the next falling edge
    always @(negedge clk) begin
        if (mon_pend) begin
            if (sbq.size() == 0) begin
                check(1, 0, "R12 unexpected read result");
            end else begin
                exp_t e;
                e = sbq.pop_front();
                check(int'(rdata), int'(e.exp), e.req);
            end
        end
        mon_pend = rd_en;
    end

    // all driver tasks start and end one time unit after a rising edge
    task automatic wr(input logic [7:0] a, input logic [7:0] d);
        wr_en = 1'b1; addr = a; wdata = d;
        @(posedge clk); #1;
        wr_en = 1'b0;
    endtask

    task automatic rd(input logic [7:0] a, input logic [7:0] exp, input string req);
        exp_t e;
        e.exp = exp; e.req = req;
        sbq.push_back(e);
        rd_en = 1'b1; addr = a;
        @(posedge clk); #1;
        rd_en = 1'b0;
    endtask

    task automatic pulse_stop();
        stop_i = 1'b1;
        @(posedge clk); #1;
        stop_i = 1'b0;
    endtask

    task automatic wait_idle();
        for (int i = 0; i < 4 * CC; i++) begin
            @(negedge clk);
            if (!busy) break;
        end
        @(posedge clk); #1;
    endtask

    task automatic stop_count(input int exp, input string req);
        int n;
        n = 0;
        pulse_stop();
        for (int i = 0; i < 4 * CC; i++) begin
            @(negedge clk);
            if (busy) n++;
            else break;
        end
        check(n, exp, req);
        @(posedge clk); #1;
    endtask

    task automatic power_up(input logic clear_nv);
        rst_n = 1'b0;
        if (clear_nv) nv_clear_n = 1'b0;
        repeat (3) @(posedge clk);
        #1;
        rst_n = 1'b1;
        nv_clear_n = 1'b1;
        @(negedge clk);
        check(busy, 1, "R10 busy during recall");
        @(posedge clk); #1;
        @(negedge clk);
        check(busy, 0, "R10 busy drops after recall");
        @(posedge clk); #1;
    endtask

    task automatic drain();
        @(posedge clk); #1;
        @(posedge clk); #1;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        fails++;
        $display("FAIL watchdog expired actual=running expected=finished");
        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

    initial begin
        @(posedge clk); #1;
        power_up(1'b1);

        // factory state of the pin controls
        @(negedge clk);
        check(pullup_en, 4'h0, "R9 reset pullup_en");
        check(pulldown_en, 4'h0, "R9 reset pulldown_en");
        check(delay_sel, 2'd3, "R9 reset delay_sel");
        @(posedge clk); #1;
        rd(8'hF4, 8'h01, "R9 factory pin control byte");
        rd(8'hF9, 8'h00, "R12 config reads mode 0");

        // reserved space
        wr(8'h50, 8'hAA);
        rd(8'h50, 8'h00, "R1 reserved after write");
        rd(8'hEF, 8'h00, "R1 reserved top");

        // SRAM bytes and idle STOP
        wr(8'hFA, 8'h5A);
        wr(8'hFF, 8'hC3);
        stop_count(0, "R11 no busy on idle STOP");
        rd(8'hFA, 8'h5A, "R2 SRAM FA");
        rd(8'hFF, 8'hC3, "R2 SRAM FF");

        // status byte
        pin_lvl = 4'b1010;
        rd(8'hF8, 8'h0A, "R8 status 1010");
        pin_lvl = 4'b0101;
        rd(8'hF8, 8'h05, "R8 status 0101");

        // user byte commit
        wr(8'h06, 8'h11);
        rd(8'h06, 8'h00, "R3 old value before commit");
        stop_count(CC, "R3 commit busy length");
        rd(8'h06, 8'h11, "R3 value after commit");

        // page merge and foreign-page rejection
        for (int k = 0; k < 8; k++) wr(8'(8'h08 + k), 8'(8'h21 + k));
        stop_count(CC, "R4 full page commit");
        wr(8'h0A, 8'h99);
        wr(8'h12, 8'h77);
        stop_count(CC, "R4 partial page commit");
        for (int k = 0; k < 8; k++) begin
            rd(8'(8'h08 + k), (k == 2) ? 8'h99 : 8'(8'h21 + k), "R4 page contents");
        end
        rd(8'h12, 8'h00, "R4 other page ignored");

        // writes during a commit
        wr(8'h20, 8'h44);
        pulse_stop();
        wr(8'hFA, 8'h11);
        wr(8'h21, 8'h55);
        wr(8'hF9, 8'h01);
        wait_idle();
        rd(8'hFA, 8'h5A, "R7 SRAM write refused");
        rd(8'hF9, 8'h00, "R7 config write refused");
        rd(8'h20, 8'h44, "R7 committed byte");
        stop_count(0, "R7 refused user write left nothing pending");
        rd(8'h21, 8'h00, "R7 user write refused");

        // committed shadow writes
        wr(8'hF0, 8'h05);
        wr(8'hF5, 8'h00);
        @(negedge clk);
        check(pullup_en, 4'h5, "R9 pullup follows F0");
        check(pulldown_en, 4'b0010, "R9 pulldown follows F5");
        @(posedge clk); #1;
        stop_count(CC, "R6 shadow commit busy");

        // volatile shadow writes
        wr(8'hF9, 8'h01);
        wr(8'hF0, 8'h0F);
        wr(8'hF1, 8'h01);
        @(negedge clk);
        check(pullup_en, 4'hF, "R5 volatile write takes effect");
        check(delay_sel, 2'd1, "R9 delay_sel follows F1");
        @(posedge clk); #1;
        stop_count(0, "R5 no commit in volatile mode");
        rd(8'hF9, 8'h01, "R12 config reads mode 1");

        // power cycle without clearing the array
        drain();
        power_up(1'b0);
        @(negedge clk);
        check(pullup_en, 4'h5, "R5 committed pullup restored");
        check(pulldown_en, 4'b0010, "R6 committed pulldown kept");
        check(delay_sel, 2'd3, "R5 volatile delay discarded");
        @(posedge clk); #1;
        rd(8'hF9, 8'h00, "R2 config cleared by reset");
        rd(8'hFA, 8'h00, "R2 SRAM cleared by reset");
        rd(8'h06, 8'h11, "R3 user byte kept");
        rd(8'h0A, 8'h99, "R4 merged byte kept");
        rd(8'hF5, 8'h00, "R6 shadow byte kept");
        drain();

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end

endmodule